// File: doc/BRIEF.md
# Dual-CPU Level-One Interrupt Controller

This block gathers a wide vector of level-sensitive interrupt sources and drives one interrupt line into each of two processors. Each processor owns a private bank of 32-bit registers. Half of the bank holds enable masks that software reads and writes. The other half holds status words that show the live source levels. A processor's line goes high whenever some source is raised and that processor's bank has it enabled.

Software reaches the banks through a simple 32-bit register port. Writes commit on the clock edge; reads return data combinationally from the current address. The `WORDS` parameter sets the number of 32-bit words per half-bank. The value 4 gives 128 sources and the value 2 gives 64; the address layout and the bit mapping scale with it.

Inside each bank the words run in descending order. Word 0 holds the highest-numbered sources, and source 0 sits in bit 0 of the last word. Nothing is latched on the source side, so a status bit follows its input line directly.

Top module: `l1ic_top`

## Requirements
- R1: Processor c's bank starts at byte offset c*8*WORDS. Enable word w is at bank+4*w and status word w is at bank+4*(WORDS+w). This gives a bank stride of 0x20 for WORDS=4.
- R2: Bit b of word w, in both the enable and status halves, stands for source number 32*(WORDS-1-w)+b. Source 0 is therefore bit 0 of the last word.
- R3: An enable word reads back exactly the last value written to it, and a write replaces all 32 bits.
- R4: A status word shows the current raw source levels whatever the enables hold. Both processors' banks show identical status, and writes to status offsets change nothing.
- R5: cpuIrq[c] is a register holding the OR over all words of (status AND processor c's enable). It changes on the first clock edge after a source or enable change.
- R6: The two enable banks are independent. A source enabled in both banks raises both outputs in the same cycle.
- R7: Reset is asynchronous and active low. It clears every enable word and holds both outputs low.
- R8: Offsets past the last status word of processor 1, and offsets that are not multiples of 4, read as zero. Writes to them have no effect.
- R9: With WORDS=2 (64 sources) the bank stride is 0x10 and word 0 holds sources 32 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, commits at the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqSrc | input | 32*WORDS | Level-sensitive source lines, index = source number |
| cpuIrq | output | 2 | Interrupt request to processor 0 (bit 0) and processor 1 (bit 1) |

## Verification
A corrupted enable bit shows up at the ports in two ways. Its own source raises, or fails to raise, the wrong processor's line one clock after the source moves. A readback of that enable word at the same offset also shows the wrong value at once. A wrong word-order or bank decode sends a single source to the wrong bit or word in the status readback, and the checks catch this with single-bit patterns at both ends of the vector. A missing output register shows as cpuIrq moving in the same cycle as the source rather than one edge later.

// File: rtl/l1ic_pkg.sv
package l1ic_pkg;
  localparam int WordBits = 32;

  // Decoded access, passed from the address decoder to the datapath
  typedef struct packed {
    logic       hit;       // aligned and inside the mapped range
    logic       wrEn;      // write requested this cycle
    logic       cpuSel;    // which processor bank
    logic       isStatus;  // status half of the bank
    logic [1:0] wordSel;   // word within the half-bank
  } l1ic_strb_t;
endpackage

// File: rtl/l1ic_decode.sv
module l1ic_decode
  import l1ic_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output l1ic_strb_t        strb
);
  localparam int WL = $clog2(WORDS);

  logic [ADDR_W-3:0] wordIdx;
  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    strb.hit      = (busAddr[1:0] == 2'b00) && (wordIdx[ADDR_W-3:WL+2] == '0);
    strb.wrEn     = busWrEn;
    strb.cpuSel   = wordIdx[WL+1];
    strb.isStatus = wordIdx[WL];
    strb.wordSel  = 2'(wordIdx[WL-1:0]);
  end
endmodule

// File: rtl/l1ic_datapath.sv
module l1ic_datapath
  import l1ic_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  l1ic_strb_t                strb,
  input  logic [WordBits-1:0]       wrData,
  input  logic [WordBits*WORDS-1:0] irqSrc,
  output logic [WordBits-1:0]       rdData,
  output logic [1:0]                cpuIrq
);
  logic [WordBits-1:0] enReg [2][WORDS];
  logic [WordBits-1:0] statusWord [WORDS];
  logic [1:0]          anyPend;

  // Descending word order: word 0 carries the top sources
  for (genvar w = 0; w < WORDS; w++) begin : g_status
    assign statusWord[w] = irqSrc[WordBits*(WORDS-1-w) +: WordBits];
  end

  for (genvar c = 0; c < 2; c++) begin : g_cpu
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enReg[c][w] <= '0;
        end else if (strb.wrEn && strb.hit && !strb.isStatus &&
                     strb.cpuSel == 1'(c) && strb.wordSel == 2'(w)) begin
          enReg[c][w] <= wrData;
        end
      end
    end
  end

  always_comb begin
    anyPend = '0;
    for (int c = 0; c < 2; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        anyPend[c] = anyPend[c] | (|(enReg[c][w] & statusWord[w]));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= '0;
    else       cpuIrq <= anyPend;
  end

  always_comb begin
    rdData = '0;
    if (strb.hit) begin
      for (int c = 0; c < 2; c++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (strb.cpuSel == 1'(c) && strb.wordSel == 2'(w)) begin
            rdData = strb.isStatus ? statusWord[w] : enReg[c][w];
          end
        end
      end
    end
  end
endmodule

// File: rtl/l1ic_top.sv
module l1ic_top
  import l1ic_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busWrEn,
  input  logic [31:0]               busWrData,
  output logic [31:0]               busRdData,
  input  logic [32*WORDS-1:0]       irqSrc,
  output logic [1:0]                cpuIrq
);
  l1ic_strb_t strb;

  l1ic_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  l1ic_datapath #(.WORDS(WORDS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .irqSrc (irqSrc),
    .rdData (busRdData),
    .cpuIrq (cpuIrq)
  );
endmodule

// File: rtl/l1ic_checker.sv
module l1ic_checker #(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [31:0]         busWrData,
  input logic [31:0]         busRdData,
  input logic [32*WORDS-1:0] irqSrc,
  input logic [1:0]          cpuIrq
);
  localparam logic [ADDR_W-1:0] MapEnd      = ADDR_W'(16 * WORDS);
  localparam logic [ADDR_W-1:0] Cpu0LastSt  = ADDR_W'(4 * (2 * WORDS - 1));
  localparam logic [ADDR_W-1:0] Cpu1FirstSt = ADDR_W'(12 * WORDS);

  AST_IDLE_SOURCES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (irqSrc == '0) |=> (cpuIrq == 2'b00));  // R5

  AST_LAST_WORD_LOW_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == Cpu0LastSt) |-> (busRdData == irqSrc[31:0]));  // R2

  AST_FIRST_WORD_HIGH_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == Cpu1FirstSt) |-> (busRdData == irqSrc[32*WORDS-1 -: 32]));  // R4

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= MapEnd || busAddr[1:0] != 2'b00) |-> (busRdData == '0));  // R8

  AST_ENABLE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == '0) |=> (busAddr != '0 || busRdData == $past(busWrData)));  // R3

  AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (cpuIrq == 2'b00));  // R7
endmodule

bind l1ic_top l1ic_checker #(.WORDS(WORDS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqSrc    (irqSrc),
  .cpuIrq    (cpuIrq)
);

// File: tb/l1ic_top_tb_top.sv
`timescale 1ns/1ps
module l1ic_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Main instance, 128 sources
  logic [7:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [127:0] irqSrc = '0;
  logic [1:0]   cpuIrq;

  // Narrow instance, 64 sources
  logic [7:0]  busAddr2 = '0;
  logic        busWrEn2 = 1'b0;
  logic [31:0] busWrData2 = '0;
  logic [31:0] busRdData2;
  logic [63:0] irqSrc2 = '0;
  logic [1:0]  cpuIrq2;

  l1ic_top #(.WORDS(4), .ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqSrc(irqSrc), .cpuIrq(cpuIrq)
  );

  l1ic_top #(.WORDS(2), .ADDR_W(8)) dut2_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr2), .busWrEn(busWrEn2),
    .busWrData(busWrData2), .busRdData(busRdData2), .irqSrc(irqSrc2), .cpuIrq(cpuIrq2)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic         wr;
    logic [7:0]   addr;
    logic [31:0]  data;
    logic [127:0] src;
    logic [31:0]  expRd;
    logic [1:0]   expIrq;
    logic [7:0]   req;
  } vec_t;

  localparam int NVec = 12;
  localparam vec_t Vecs [NVec] = '{
    '{1'b0, 8'h1C, 32'h0,        128'd1,           32'h1,        2'b00, 8'd2}, // R2 source 0 in last status word
    '{1'b1, 8'h0C, 32'h1,        128'd1,           32'h1,        2'b01, 8'd5}, // R5 R3 enable cpu0 source 0
    '{1'b1, 8'h20, 32'h80000000, 128'd1 << 127,    32'h80000000, 2'b10, 8'd1}, // R1 cpu1 bank at 0x20
    '{1'b0, 8'h10, 32'h0,        (128'd1 << 127) | 128'd1, 32'h80000000, 2'b11, 8'd6}, // R6
    '{1'b1, 8'h1C, 32'hFFFFFFFF, 128'd1,           32'h1,        2'b01, 8'd4}, // R4 status write ignored
    '{1'b1, 8'h0C, 32'h0,        128'd1,           32'h0,        2'b00, 8'd3}, // R3 full-word replace
    '{1'b1, 8'h44, 32'h0000FFFF, 128'd0,           32'h0,        2'b00, 8'd8}, // R8 out of range
    '{1'b1, 8'h02, 32'hFFFFFFFF, 128'd1,           32'h0,        2'b00, 8'd8}, // R8 misaligned
    '{1'b0, 8'h00, 32'h0,        128'd0,           32'h0,        2'b00, 8'd8}, // R8 misaligned write left enable alone
    '{1'b1, 8'h28, 32'h4,        128'd1 << 34,     32'h4,        2'b10, 8'd2}, // R2 source 34 in word 2
    '{1'b1, 8'h08, 32'h4,        128'd1 << 34,     32'h4,        2'b11, 8'd6}, // R6 both cpus
    '{1'b0, 8'h38, 32'h0,        128'd3 << 34,     32'hC,        2'b11, 8'd4}  // R4 cpu1 status mirrors
  };

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    busAddr = 8'h0C;
    #1;
    chk("R7 reset cpuIrq", 32'(cpuIrq), 32'h0);
    chk("R7 reset enable", busRdData, 32'h0);

    // Vector table
    for (int i = 0; i < NVec; i++) begin
      @(negedge clk);
      irqSrc = Vecs[i].src;
      busAddr = Vecs[i].addr;
      busWrEn = Vecs[i].wr;
      busWrData = Vecs[i].data;
      @(negedge clk);
      busWrEn = 1'b0;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d rd", Vecs[i].req, i), busRdData, Vecs[i].expRd);
      chk($sformatf("R%0d vec%0d irq", Vecs[i].req, i), 32'(cpuIrq), 32'(Vecs[i].expIrq));
    end

    // R5 one-edge latency: enables hold source 34 for both cpus
    irqSrc = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 quiet", 32'(cpuIrq), 32'h0);
    irqSrc = 128'd1 << 34;
    #1;
    chk("R5 not yet", 32'(cpuIrq), 32'h0);
    @(negedge clk);
    chk("R5 after edge", 32'(cpuIrq), 32'h3);
    irqSrc = '0;
    @(negedge clk);
    chk("R5 falls", 32'(cpuIrq), 32'h0);

    // R7 reset in mid-run clears enables
    irqSrc = 128'd1 << 34;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R7 async clear", 32'(cpuIrq), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    busAddr = 8'h28;
    @(negedge clk);
    @(negedge clk);
    chk("R7 enable cleared", busRdData, 32'h0);
    chk("R7 output stays low", 32'(cpuIrq), 32'h0);

    // R9 narrow variant
    irqSrc2 = 64'h80000000_00000001;
    busAddr2 = 8'h08;
    #1;
    chk("R9 word0 upper", busRdData2, 32'h80000000);
    busAddr2 = 8'h0C;
    #1;
    chk("R9 last word low", busRdData2, 32'h1);
    @(negedge clk);
    busAddr2 = 8'h10;
    busWrEn2 = 1'b1;
    busWrData2 = 32'h80000000;
    @(negedge clk);
    busWrEn2 = 1'b0;
    @(negedge clk);
    chk("R9 cpu1 bank at 0x10", busRdData2, 32'h80000000);
    chk("R9 cpu1 irq", 32'(cpuIrq2), 32'h2);
    busAddr2 = 8'h18;
    #1;
    chk("R9 cpu1 status", busRdData2, 32'h80000000);
    busAddr2 = 8'h20;
    #1;
    chk("R9 unmapped", busRdData2, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule